// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of signed three-axis acceleration samples and classifies short impacts as single or double taps. For each sample it forms a performance index, the sum of the absolute values of the three axes. A sample qualifies as a tap sample when that index lies inside a programmable band. The lower edge of the band is an 8-bit register. The upper edge is an 8-bit register doubled. A tap begins on the first qualifying sample that follows a non-qualifying one.

After a first tap the block opens a timed decision interval. Three 8-bit timer registers shape it: a latency, a minimum separation and a tap window. All three are counted in timer units. One unit is two sample periods, or four when the fast-rate input is set. A second tap that begins early enough and late enough turns the event into a double tap. Otherwise the event is reported as a single tap when the window runs out.

The result is held in a single-tap flag, a double-tap flag and a six-bit one-hot direction code until a release pulse arrives. The direction comes from the axis with the largest magnitude at the first tap, together with its sign.

Top module: `tap_detector`

## Requirements
- R1: The performance index of a sample is |acc_x|+|acc_y|+|acc_z|. A sample qualifies when th_lo <= index <= 2*th_hi, both bounds inclusive. A tap starts on a qualifying sample whose previous sample (previous smp_vld cycle) did not qualify. After reset the previous sample counts as not qualifying.
- R2: The upper bound of the band is twice the th_hi register value, so an index equal to 2*th_hi qualifies and 2*th_hi+1 does not.
- R3: One timer unit is 2 samples when fast_rate=0 and 4 samples when fast_rate=1. The limits in samples are L=t_lat*unit, S=t_sep*unit and W=t_win*unit.
- R4: Let k be the number of samples since the first tap, so the next sample has k=1. A tap start with k <= L is ignored, and the event can still end as a single tap.
- R5: A tap start with L < k, S <= k and k <= W ends the event as a double tap. Tap starts that meet none of these conditions are ignored and do not begin a new event.
- R6: When no valid second tap has occurred, the event ends as a single tap at the sample with k == W. If W is 0, it ends at the sample with k == 1.
- R7: tap_dir is one-hot while a flag is set and 0 otherwise. Its bits are [5] -X, [4] +X, [3] -Y, [2] +Y, [1] -Z, [0] +Z. The axis is the one with the largest magnitude at the first tap, with ties resolved in the order X, then Y, then Z. The minus bit is used when that axis is negative.
- R8: An int_rel pulse clears single_tap, double_tap and tap_dir on the next clock. A report in the same cycle wins over the release.
- R9: After reset all outputs are 0. The two flags are never set together. A report overwrites the flags and the direction on the clock after its sample, and the outputs change only after a sample or a release.
- R10: Once an event has been reported, the next tap start begins a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Strobe marking a new sample |
| acc_x | input | DW | Signed X acceleration |
| acc_y | input | DW | Signed Y acceleration |
| acc_z | input | DW | Signed Z acceleration |
| th_lo | input | TW | Lower performance-index bound |
| th_hi | input | TW | Upper bound, doubled internally |
| t_lat | input | TW | Latency in timer units |
| t_win | input | TW | Tap window in timer units |
| t_sep | input | TW | Minimum separation in timer units |
| fast_rate | input | 1 | Selects 4 samples per timer unit |
| int_rel | input | 1 | Release pulse clearing the flags |
| single_tap | output | 1 | Latched single-tap flag |
| double_tap | output | 1 | Latched double-tap flag |
| tap_dir | output | 6 | One-hot direction of the event |

## Verification
The outputs are compared on every clock against a behavioural model. A sample counter that is off by one moves a single-tap report by one sample period, which shows up within two clocks as a wrong flag. A stuck decision state shows up as a missing report at the end of the window or as a double tap that never appears. A wrong edge-detect or band comparison shows as a report for stimulus that should be ignored, or no report at all. Directional faults are seen on the very clock the flag rises, because the code is captured at the first tap and presented together with the flag.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int DIR_W = 6;
  localparam int D_XN = 5;
  localparam int D_XP = 4;
  localparam int D_YN = 3;
  localparam int D_YP = 2;
  localparam int D_ZN = 1;
  localparam int D_ZP = 0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tap_index.sv
module tap_index
  import tap_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 8,
  localparam int PW = DW + 2
) (
  input  logic [2:0][DW-1:0] acc,
  input  logic [TW-1:0]      th_lo,
  input  logic [TW-1:0]      th_hi,
  output logic               in_rng,
  output logic [DIR_W-1:0]   dir_now
);
  logic [2:0][DW-1:0] mag;
  logic [2:0]         neg;
  logic [PW-1:0]      pidx;
  logic [PW-1:0]      lo_b;
  logic [PW-1:0]      hi_b;

  for (genvar g = 0; g < 3; g++) begin : g_axis
    assign neg[g] = acc[g][DW-1];
    assign mag[g] = neg[g] ? (~acc[g] + 1'b1) : acc[g];
  end

  assign pidx   = PW'(mag[0]) + PW'(mag[1]) + PW'(mag[2]);
  assign lo_b   = PW'(th_lo);
  assign hi_b   = PW'({th_hi, 1'b0});
  assign in_rng = (pidx >= lo_b) && (pidx <= hi_b);

  always_comb begin
    dir_now = '0;
    if (mag[0] >= mag[1] && mag[0] >= mag[2]) begin
      dir_now[neg[0] ? D_XN : D_XP] = 1'b1;
    end else if (mag[1] >= mag[2]) begin
      dir_now[neg[1] ? D_YN : D_YP] = 1'b1;
    end else begin
      dir_now[neg[2] ? D_ZN : D_ZP] = 1'b1;
    end
  end
endmodule

// File: rtl/tap_seq.sv
module tap_seq
  import tap_pkg::*;
#(
  parameter int TW = 8,
  localparam int CW = TW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic             in_rng,
  input  logic [DIR_W-1:0] dir_now,
  input  logic [TW-1:0]    t_lat,
  input  logic [TW-1:0]    t_win,
  input  logic [TW-1:0]    t_sep,
  input  logic             fast_rate,
  output logic             rep_single,
  output logic             rep_double,
  output logic [DIR_W-1:0] rep_dir
);
  seq_state_e       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DIR_W-1:0] dir_q, dir_d;
  logic             prev_q, prev_d;
  logic             start;
  logic [CW-1:0]    k_now;
  logic [CW-1:0]    lat_l, win_l, sep_l;

  function automatic logic [CW-1:0] to_samples(input logic [TW-1:0] t, input logic f);
    return f ? (CW'(t) << 2) : (CW'(t) << 1);
  endfunction

  assign lat_l = to_samples(t_lat, fast_rate);
  assign win_l = to_samples(t_win, fast_rate);
  assign sep_l = to_samples(t_sep, fast_rate);
  assign start = in_rng & ~prev_q;
  assign k_now = cnt_q + 1'b1;
  assign rep_dir = dir_q;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    dir_d      = dir_q;
    prev_d     = prev_q;
    rep_single = 1'b0;
    rep_double = 1'b0;
    if (smp_vld) begin
      prev_d = in_rng;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
            dir_d = dir_now;
          end
        end
        ST_WAIT: begin
          cnt_d = k_now;
          if (start && k_now > lat_l && k_now >= sep_l && k_now <= win_l) begin
            rep_double = 1'b1;
            st_d       = ST_IDLE;
          end else if (k_now >= win_l) begin
            rep_single = 1'b1;
            st_d       = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      dir_q  <= '0;
      prev_q <= 1'b0;
    end else if (smp_vld) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/tap_flags.sv
module tap_flags
  import tap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rep_single,
  input  logic             rep_double,
  input  logic [DIR_W-1:0] rep_dir,
  input  logic             int_rel,
  output logic             single_tap,
  output logic             double_tap,
  output logic [DIR_W-1:0] tap_dir
);
  logic             s_d, d_d;
  logic [DIR_W-1:0] dir_d;
  logic             upd;

  assign upd = rep_single | rep_double | int_rel;

  always_comb begin
    s_d   = 1'b0;
    d_d   = 1'b0;
    dir_d = '0;
    if (rep_single || rep_double) begin
      s_d   = rep_single;
      d_d   = rep_double;
      dir_d = rep_dir;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_tap <= 1'b0;
      double_tap <= 1'b0;
      tap_dir    <= '0;
    end else if (upd) begin
      single_tap <= s_d;
      double_tap <= d_d;
      tap_dir    <= dir_d;
    end
  end
endmodule

// File: rtl/tap_detector.sv
module tap_detector
  import tap_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] acc_x,
  input  logic signed [DW-1:0] acc_y,
  input  logic signed [DW-1:0] acc_z,
  input  logic [TW-1:0]        th_lo,
  input  logic [TW-1:0]        th_hi,
  input  logic [TW-1:0]        t_lat,
  input  logic [TW-1:0]        t_win,
  input  logic [TW-1:0]        t_sep,
  input  logic                 fast_rate,
  input  logic                 int_rel,
  output logic                 single_tap,
  output logic                 double_tap,
  output logic [DIR_W-1:0]     tap_dir
);
  logic [2:0][DW-1:0] acc;
  logic               in_rng;
  logic [DIR_W-1:0]   dir_now;
  logic               rep_single, rep_double;
  logic [DIR_W-1:0]   rep_dir;

  assign acc = {acc_z, acc_y, acc_x};

  tap_index #(.DW(DW), .TW(TW)) u_index (
    .acc     (acc),
    .th_lo   (th_lo),
    .th_hi   (th_hi),
    .in_rng  (in_rng),
    .dir_now (dir_now)
  );

  tap_seq #(.TW(TW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .in_rng     (in_rng),
    .dir_now    (dir_now),
    .t_lat      (t_lat),
    .t_win      (t_win),
    .t_sep      (t_sep),
    .fast_rate  (fast_rate),
    .rep_single (rep_single),
    .rep_double (rep_double),
    .rep_dir    (rep_dir)
  );

  tap_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rep_single (rep_single),
    .rep_double (rep_double),
    .rep_dir    (rep_dir),
    .int_rel    (int_rel),
    .single_tap (single_tap),
    .double_tap (double_tap),
    .tap_dir    (tap_dir)
  );
endmodule

// File: rtl/tap_detector_chk.sv
module tap_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_vld,
  input logic       int_rel,
  input logic       single_tap,
  input logic       double_tap,
  input logic [5:0] tap_dir
);
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_tap && double_tap));

  // R7
  dir_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_tap || double_tap) |-> ($countones(tap_dir) == 1));

  // R7
  dir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_tap || double_tap) |-> (tap_dir == 6'd0));

  // R8
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rel && !smp_vld) |=> (!single_tap && !double_tap));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !int_rel) |=> $stable({single_tap, double_tap, tap_dir}));
endmodule

bind tap_detector tap_detector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_vld    (smp_vld),
  .int_rel    (int_rel),
  .single_tap (single_tap),
  .double_tap (double_tap),
  .tap_dir    (tap_dir)
);

// File: tb/tb_tap_detector.sv
module tb_tap_detector;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TW = 8;

  logic                 clk;
  logic                 rst_n;
  logic                 smp_vld;
  logic signed [DW-1:0] acc_x, acc_y, acc_z;
  logic [TW-1:0]        th_lo, th_hi, t_lat, t_win, t_sep;
  logic                 fast_rate;
  logic                 int_rel;
  logic                 single_tap, double_tap;
  logic [5:0]           tap_dir;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R9";
  bit    done = 0;

  int m_prev, m_busy, m_k, m_dir;
  int e_s, e_d, e_dir;

  tap_detector #(.DW(DW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
    .th_lo(th_lo), .th_hi(th_hi), .t_lat(t_lat), .t_win(t_win), .t_sep(t_sep),
    .fast_rate(fast_rate), .int_rel(int_rel),
    .single_tap(single_tap), .double_tap(double_tap), .tap_dir(tap_dir)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // behavioural reference, evaluated once per clock from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_busy = 0; m_k = 0; m_dir = 0;
      e_s = 0; e_d = 0; e_dir = 0;
    end else begin
      int ax, ay, az, pidx, inr, st, unit, dnow, rs, rd;
      rs = 0; rd = 0;
      if (smp_vld) begin
        ax = iabs(int'(acc_x)); ay = iabs(int'(acc_y)); az = iabs(int'(acc_z));
        pidx = ax + ay + az;
        inr = (pidx >= int'(th_lo) && pidx <= 2 * int'(th_hi)) ? 1 : 0;
        st = (inr == 1 && m_prev == 0) ? 1 : 0;
        m_prev = inr;
        if (ax >= ay && ax >= az) dnow = (acc_x < 0) ? 32 : 16;
        else if (ay >= az)        dnow = (acc_y < 0) ? 8 : 4;
        else                      dnow = (acc_z < 0) ? 2 : 1;
        unit = fast_rate ? 4 : 2;
        if (m_busy == 1) begin
          m_k = m_k + 1;
          if (st == 1 && m_k > int'(t_lat) * unit && m_k >= int'(t_sep) * unit &&
              m_k <= int'(t_win) * unit) begin
            rd = 1; m_busy = 0;
          end else if (m_k >= int'(t_win) * unit) begin
            rs = 1; m_busy = 0;
          end
        end else if (st == 1) begin
          m_busy = 1; m_k = 0; m_dir = dnow;
        end
      end
      if (rs == 1 || rd == 1) begin
        e_s = rs; e_d = rd; e_dir = m_dir;
      end else if (int_rel) begin
        e_s = 0; e_d = 0; e_dir = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_tag, "single_tap", int'(single_tap), e_s);
      chk(cur_tag, "double_tap", int'(double_tap), e_d);
      chk(cur_tag, "tap_dir", int'(tap_dir), e_dir);
    end
  end

  task automatic smp(input int x, input int y, input int z);
    smp_vld = 1; acc_x = DW'(x); acc_y = DW'(y); acc_z = DW'(z);
    @(negedge clk);
    smp_vld = 0;
    @(negedge clk);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) smp(0, 0, 0);
  endtask

  task automatic release_flags();
    int_rel = 1;
    @(negedge clk);
    int_rel = 0;
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input int s, input int d, input int dir);
    chk(tag, "single flag", int'(single_tap), s);
    chk(tag, "double flag", int'(double_tap), d);
    chk(tag, "direction", int'(tap_dir), dir);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; smp_vld = 0; int_rel = 0; fast_rate = 0;
    acc_x = '0; acc_y = '0; acc_z = '0;
    th_lo = 8'd20; th_hi = 8'd40;
    t_lat = 8'd1; t_sep = 8'd2; t_win = 8'd5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_out("R9", 0, 0, 0);

    // single tap, window W=10 samples
    cur_tag = "R6";
    smp(50, 0, 0); quiet(9);
    expect_out("R6", 0, 0, 0);
    quiet(1);
    expect_out("R6", 1, 0, 16);
    release_flags();
    expect_out("R8", 0, 0, 0);

    // double tap at k=5
    cur_tag = "R5";
    smp(0, -50, 0); quiet(4); smp(0, 50, 0); quiet(2);
    expect_out("R5", 0, 1, 8);
    release_flags();

    // double tap on the window edge k=W=10
    smp(0, 0, -50); quiet(9); smp(50, 0, 0); quiet(1);
    expect_out("R5", 0, 1, 2);
    release_flags();

    // second tap inside latency (k=2) ignored
    cur_tag = "R4";
    smp(0, 0, 50); quiet(1); smp(0, 0, 50); quiet(10);
    expect_out("R4", 1, 0, 1);
    release_flags();

    // after latency but before separation (S=6, k=4) ignored
    t_sep = 8'd3;
    smp(-50, 0, 0); quiet(3); smp(0, 50, 0); quiet(10);
    expect_out("R5", 1, 0, 32);
    release_flags();
    t_sep = 8'd2;

    // fast rate: L=4, S=8, W=12; k=9 is a double, k=4 is not
    cur_tag = "R3";
    fast_rate = 1; t_win = 8'd3;
    smp(0, 50, 0); quiet(8); smp(50, 0, 0); quiet(1);
    expect_out("R3", 0, 1, 4);
    release_flags();
    smp(0, 50, 0); quiet(3); smp(50, 0, 0); quiet(12);
    expect_out("R3", 1, 0, 4);
    release_flags();
    fast_rate = 0; t_win = 8'd5;

    // band edges
    cur_tag = "R1";
    smp(0, 0, 100); quiet(12);
    expect_out("R2", 0, 0, 0);
    smp(81, 0, 0); quiet(12);
    expect_out("R2", 0, 0, 0);
    smp(0, 0, -80); quiet(12);
    expect_out("R2", 1, 0, 2);
    release_flags();
    smp(10, 5, 4); quiet(12);
    expect_out("R1", 0, 0, 0);
    smp(10, -10, 0); quiet(12);
    expect_out("R1", 1, 0, 16);
    release_flags();
    th_hi = 8'd50;
    smp(0, 0, 100); quiet(12);
    expect_out("R2", 1, 0, 1);
    release_flags();
    th_hi = 8'd40;

    // direction tie Y over Z, negative sign
    cur_tag = "R7";
    smp(0, -30, 30); quiet(12);
    expect_out("R7", 1, 0, 8);
    release_flags();

    // held sample in band does not restart
    smp(50, 0, 0); quiet(4); smp(50, 0, 0); smp(50, 0, 0); quiet(12);
    expect_out("R1", 0, 1, 16);

    // back-to-back events; report overwrites an unreleased flag
    cur_tag = "R10";
    smp(0, 50, 0); quiet(12);
    expect_out("R10", 1, 0, 4);
    release_flags();

    // release held through the report sample
    cur_tag = "R8";
    int_rel = 1;
    smp(0, 0, 50); quiet(12);
    expect_out("R8", 0, 0, 0);
    int_rel = 0;
    @(negedge clk);
    expect_out("R8", 0, 0, 0);

    // zero window: single on the first following sample
    cur_tag = "R6";
    t_win = 8'd0;
    smp(50, 0, 0); smp(0, 0, 0);
    expect_out("R6", 1, 0, 16);
    release_flags();

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule